// File: doc/BRIEF.md
# Halt and Wake-Up Sequencing Controller

This block manages the low-power halt state of a small, fully static microcontroller core. Firmware requests halt by writing a port data byte with the halt bit set. The block then drops the core clock enable and waits for a wake event. Four wake sources are possible: a rising edge on a restart pin, a multi-input wake-up request, the external reset pin driven low, and a brown-out event. The brown-out event counts only when brown-out detection is enabled.

Every wake source is synchronized to the free-running oscillator clock. The sources are then arbitrated, and reset-type sources win over resume-type sources. With the crystal clock option, a brown-out or multi-input wake first waits out an oscillator stabilization delay. The reused watchdog prescaler and counter time this delay. When the wake completes, the block restores the core clock. It also emits a one-cycle pulse that tells the core either to resume after the halt instruction or to restart from the reset vector. Every wake reloads the watchdog value with all ones.

All ports are plain control and status signals. The block has no data stream, so it has no valid/ready handshake.

Top module: `halt_wake_ctrl`

## Requirements
- R1: After reset, core_clk_en is 1, halted, resume_pulse and reset_req are 0, and wdt_value is 0.
- R2: A cycle with port_wr_en=1 and port_wr_data bit 7 set makes halted=1 and core_clk_en=0 from the next cycle. A write with bit 7 clear has no effect.
- R3: Each wake input passes through two synchronizer flops. For a wake without delay, core_clk_en=1 and the outcome pulse appear in the third cycle after the input changes.
- R4: A rising edge on restart_pin wakes the block only while it is halted, and only when clk_opt is RC (2'd1) or external (2'd2 or 2'd3). With the crystal option (2'd0) the edge is ignored. An edge seen while running has no effect.
- R5: rst_pin_n low while halted produces reset_req and never uses the stabilization delay.
- R6: brownout high while halted produces reset_req only when bo_enable=1. With the crystal option it first waits out the delay. With bo_enable=0 it is ignored.
- R7: mwake_req high while halted produces resume_pulse. With the crystal option it first waits out the delay.
- R8: The stabilization delay adds 256*DIV_RATIO oscillator cycles (256 instruction cycles). While it runs, core_clk_en, halted, resume_pulse and reset_req are all 0.
- R9: Every wake loads the watchdog prescaler (wdt_value[7:0]) and counter (wdt_value[15:8]) with 0xFF. A wake without delay therefore leaves 16'hFFFF. After a delayed wake the prescaler has wrapped once, leaving 16'hFEFF.
- R10: When several sources are active together, rst_pin_n and enabled brownout win over the resume sources, and rst_pin_n wins over brownout when the delay is chosen.
- R11: resume_pulse and reset_req are each high for exactly one cycle and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Free-running oscillator clock |
| por_n | input | 1 | Asynchronous active-low power-on reset of the block |
| port_wr_en | input | 1 | Write strobe of the port data register |
| port_wr_data | input | 8 | Written byte; bit 7 requests halt |
| clk_opt | input | 2 | Clock option: 0 crystal, 1 RC, 2/3 external |
| bo_enable | input | 1 | Brown-out detection enabled |
| restart_pin | input | 1 | Restart pin, rising edge wakes |
| mwake_req | input | 1 | Multi-input wake-up request, active high |
| rst_pin_n | input | 1 | External reset pin, active low |
| brownout | input | 1 | Brown-out event, active high |
| core_clk_en | output | 1 | Clock enable for the core |
| halted | output | 1 | Block is in halt, waiting for a wake |
| resume_pulse | output | 1 | One-cycle pulse: continue after halt |
| reset_req | output | 1 | One-cycle pulse: restart from reset vector |
| wdt_value | output | 16 | Watchdog counter (high byte) and prescaler (low byte) |

## Verification
The bench runs a full sweep over the four clock-option codes, both brown-out enable values and all sixteen combinations of wake sources applied in the same cycle. For each case it computes the outcome (resume, reset or no wake), the wake latency and the final watchdog value. This separates priority errors from clock-option gating errors, and delayed paths from direct paths. Separate patterns cover a write with the halt bit clear, and a restart edge raised while running that must not count later. Throughout each stabilization delay the bench checks that every output stays low.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STAB = 2'd2
  } hwc_state_t;

  typedef enum logic [1:0] {
    OPT_XTAL = 2'd0,
    OPT_RC   = 2'd1,
    OPT_EXT  = 2'd2,
    OPT_EXT2 = 2'd3
  } clk_opt_t;

  // wake source index in the synchronized vector
  localparam int SRC_RESTART = 0;
  localparam int SRC_MWAKE   = 1;
  localparam int SRC_RSTPIN  = 2;
  localparam int SRC_BROWN   = 3;
  localparam int NUM_SRC     = 4;
endpackage

// File: rtl/hwc_sync.sv
module hwc_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= din;
        else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/hwc_wake_arb.sv
module hwc_wake_arb
  import hwc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_sync,
  input  logic               is_xtal,
  input  logic               bo_enable,
  output logic               wake,
  output logic               to_reset,
  output logic               use_delay
);
  logic restart_prev_q;
  logic restart_edge;
  logic rst_act, bo_act, mw_act, edge_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) restart_prev_q <= 1'b0;
    else restart_prev_q <= src_sync[SRC_RESTART];
  end

  assign restart_edge = src_sync[SRC_RESTART] & ~restart_prev_q;
  assign rst_act  = src_sync[SRC_RSTPIN];
  assign bo_act   = src_sync[SRC_BROWN] & bo_enable;
  assign mw_act   = src_sync[SRC_MWAKE];
  assign edge_act = restart_edge & ~is_xtal;

  always_comb begin
    wake      = 1'b0;
    to_reset  = 1'b0;
    use_delay = 1'b0;
    if (rst_act) begin
      wake     = 1'b1;
      to_reset = 1'b1;
    end else if (bo_act) begin
      wake      = 1'b1;
      to_reset  = 1'b1;
      use_delay = is_xtal;
    end else if (mw_act) begin
      wake      = 1'b1;
      use_delay = is_xtal;
    end else if (edge_act) begin
      wake = 1'b1;
    end
  end

  // R10: any reset-type source forces the reset outcome
  a_r10_reset_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sync[SRC_RSTPIN] || (src_sync[SRC_BROWN] && bo_enable)) |-> (wake && to_reset));

  // R5: the reset pin never selects the delay
  a_r5_pin_no_delay: assert property (@(posedge clk) disable iff (!rst_n)
    src_sync[SRC_RSTPIN] |-> !use_delay);
endmodule

// File: rtl/hwc_stab_timer.sv
module hwc_stab_timer #(
  parameter int DIV_RATIO = 10,
  parameter int PRE_W     = 8,
  parameter int CNT_W     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   run,
  output logic                   done,
  output logic [CNT_W+PRE_W-1:0] wdt_value
);
  localparam int DIV_W = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);
  assign done = run & tick & (pre_q == '0);
  assign wdt_value = {cnt_q, pre_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= '0;
      pre_q <= '1;
      cnt_q <= '1;
    end else if (run) begin
      if (tick) begin
        div_q <= '0;
        pre_q <= pre_q - 1'b1;
        if (pre_q == '0) cnt_q <= cnt_q - 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  // R9: every wake reloads both stages with all ones
  a_r9_load_ones: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (wdt_value == '1));

  // R8: the prescaler only moves on an instruction-cycle tick
  a_r8_prescale_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && !tick) |=> $stable(pre_q));
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import hwc_pkg::*;
#(
  parameter int DIV_RATIO   = 10,
  parameter int PRE_W       = 8,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8,
  parameter int HALT_BIT    = 7
) (
  input  logic                   osc_clk,
  input  logic                   por_n,
  input  logic                   port_wr_en,
  input  logic [DATA_W-1:0]      port_wr_data,
  input  logic [1:0]             clk_opt,
  input  logic                   bo_enable,
  input  logic                   restart_pin,
  input  logic                   mwake_req,
  input  logic                   rst_pin_n,
  input  logic                   brownout,
  output logic                   core_clk_en,
  output logic                   halted,
  output logic                   resume_pulse,
  output logic                   reset_req,
  output logic [CNT_W+PRE_W-1:0] wdt_value
);
  hwc_state_t       state_q;
  logic [NUM_SRC-1:0] src_raw, src_sync;
  logic             wake, to_reset, use_delay, is_xtal;
  logic             stab_done, stab_load;
  logic             pend_reset_q, resume_q, reset_q;

  assign is_xtal = (clk_opt == OPT_XTAL);

  always_comb begin
    src_raw              = '0;
    src_raw[SRC_RESTART] = restart_pin;
    src_raw[SRC_MWAKE]   = mwake_req;
    src_raw[SRC_RSTPIN]  = ~rst_pin_n;
    src_raw[SRC_BROWN]   = brownout;
  end

  hwc_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(osc_clk), .rst_n(por_n), .din(src_raw), .dout(src_sync)
  );

  hwc_wake_arb arb_i (
    .clk(osc_clk), .rst_n(por_n), .src_sync(src_sync), .is_xtal(is_xtal),
    .bo_enable(bo_enable), .wake(wake), .to_reset(to_reset), .use_delay(use_delay)
  );

  assign stab_load = (state_q == ST_HALT) && wake;

  hwc_stab_timer #(.DIV_RATIO(DIV_RATIO), .PRE_W(PRE_W), .CNT_W(CNT_W)) timer_i (
    .clk(osc_clk), .rst_n(por_n), .load(stab_load), .run(state_q == ST_STAB),
    .done(stab_done), .wdt_value(wdt_value)
  );

  always_ff @(posedge osc_clk or negedge por_n) begin
    if (!por_n) begin
      state_q      <= ST_RUN;
      pend_reset_q <= 1'b0;
      resume_q     <= 1'b0;
      reset_q      <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      reset_q  <= 1'b0;
      unique case (state_q)
        ST_RUN: begin
          if (port_wr_en && port_wr_data[HALT_BIT]) state_q <= ST_HALT;
        end
        ST_HALT: begin
          if (wake) begin
            pend_reset_q <= to_reset;
            if (use_delay) begin
              state_q <= ST_STAB;
            end else begin
              state_q  <= ST_RUN;
              reset_q  <= to_reset;
              resume_q <= ~to_reset;
            end
          end
        end
        ST_STAB: begin
          if (stab_done) begin
            state_q  <= ST_RUN;
            reset_q  <= pend_reset_q;
            resume_q <= ~pend_reset_q;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign core_clk_en  = (state_q == ST_RUN);
  assign halted       = (state_q == ST_HALT);
  assign resume_pulse = resume_q;
  assign reset_req    = reset_q;

  // R11: the two outcome pulses never coincide and last one cycle
  a_r11_one_outcome: assert property (@(posedge osc_clk) disable iff (!por_n)
    !(resume_pulse && reset_req));
  a_r11_pulse_short: assert property (@(posedge osc_clk) disable iff (!por_n)
    (resume_pulse || reset_req) |=> !(resume_pulse || reset_req));

  // R5: halted with the reset pin active ends in reset next cycle
  a_r5_pin_wake: assert property (@(posedge osc_clk) disable iff (!por_n)
    (halted && src_sync[SRC_RSTPIN]) |=> (reset_req && core_clk_en));

  // R8: stabilization keeps every output quiet
  a_r8_stab_quiet: assert property (@(posedge osc_clk) disable iff (!por_n)
    (state_q == ST_STAB) |-> !(core_clk_en || halted || resume_pulse || reset_req));

  // R4: with crystal option, only non-edge sources leave halt
  a_r4_xtal_edge_ignored: assert property (@(posedge osc_clk) disable iff (!por_n)
    (halted && is_xtal && !src_sync[SRC_RSTPIN] && !src_sync[SRC_MWAKE]
     && !(src_sync[SRC_BROWN] && bo_enable)) |=> halted);

  // R2: halt write while running stops the clock
  a_r2_enter_halt: assert property (@(posedge osc_clk) disable iff (!por_n)
    (core_clk_en && port_wr_en && port_wr_data[HALT_BIT]) |=> (halted && !core_clk_en));
endmodule

// File: tb/halt_wake_ctrl_tb_top.sv
module halt_wake_ctrl_tb_top;
  localparam int DIV_RATIO = 10;
  localparam int DELAY     = 256 * DIV_RATIO;
  localparam int LAT       = 3;

  logic        osc_clk = 1'b0;
  logic        por_n = 1'b0;
  logic        port_wr_en = 1'b0;
  logic [7:0]  port_wr_data = '0;
  logic [1:0]  clk_opt = 2'd0;
  logic        bo_enable = 1'b0;
  logic        restart_pin = 1'b0;
  logic        mwake_req = 1'b0;
  logic        rst_pin_n = 1'b1;
  logic        brownout = 1'b0;
  logic        core_clk_en, halted, resume_pulse, reset_req;
  logic [15:0] wdt_value;

  int n_run = 0;
  int n_fail = 0;

  always #5 osc_clk = ~osc_clk;

  halt_wake_ctrl #(.DIV_RATIO(DIV_RATIO)) dut_i (
    .osc_clk(osc_clk), .por_n(por_n), .port_wr_en(port_wr_en), .port_wr_data(port_wr_data),
    .clk_opt(clk_opt), .bo_enable(bo_enable), .restart_pin(restart_pin),
    .mwake_req(mwake_req), .rst_pin_n(rst_pin_n), .brownout(brownout),
    .core_clk_en(core_clk_en), .halted(halted), .resume_pulse(resume_pulse),
    .reset_req(reset_req), .wdt_value(wdt_value)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    restart_pin = 1'b0; mwake_req = 1'b0; rst_pin_n = 1'b1; brownout = 1'b0;
    port_wr_en = 1'b0; port_wr_data = '0;
  endtask

  task automatic do_por();
    @(negedge osc_clk);
    idle_inputs();
    por_n = 1'b0;
    @(negedge osc_clk);
    por_n = 1'b1;
    repeat (4) @(negedge osc_clk);
  endtask

  task automatic write_port(input logic [7:0] d);
    port_wr_en = 1'b1; port_wr_data = d;
    @(negedge osc_clk);
    port_wr_en = 1'b0; port_wr_data = '0;
  endtask

  // waits for an outcome pulse; returns negedge count, or 0 if none within limit
  task automatic wait_outcome(input int limit, input int delay_start, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge osc_clk);
      if (resume_pulse || reset_req) begin n = i; return; end
      if (i >= delay_start && delay_start > 0)
        check(!core_clk_en && !halted, "R8 outputs low during delay",
              {core_clk_en, halted}, 0);
    end
  endtask

  task automatic run_case(input int opt, input int boe, input int mask);
    bit r_s, m_s, p_s, b_s, xtal, exp_wake, exp_reset, exp_delay;
    int n, exp_n;
    r_s = mask[0]; m_s = mask[1]; p_s = mask[2]; b_s = mask[3];
    xtal = (opt == 0);
    exp_wake = 0; exp_reset = 0; exp_delay = 0;
    if (p_s) begin exp_wake = 1; exp_reset = 1; end
    else if (b_s && boe) begin exp_wake = 1; exp_reset = 1; exp_delay = xtal; end
    else if (m_s) begin exp_wake = 1; exp_delay = xtal; end
    else if (r_s && !xtal) exp_wake = 1;

    do_por();
    clk_opt = 2'(opt); bo_enable = boe[0];
    @(negedge osc_clk);
    write_port(8'h80);
    check(halted && !core_clk_en, "R2 halt entered", {halted, core_clk_en}, 2);
    restart_pin = r_s; mwake_req = m_s; rst_pin_n = ~p_s; brownout = b_s;
    exp_n = exp_delay ? LAT + DELAY : LAT;
    wait_outcome(exp_wake ? exp_n + 20 : 30, exp_delay ? LAT : 0, n);
    if (!exp_wake) begin
      check(n == 0 && halted && !core_clk_en, "R4/R6 no wake expected (R4 R6)", n, 0);
    end else begin
      check(n == exp_n, exp_delay ? "R8 delayed wake latency" : "R3 direct wake latency", n, exp_n);
      check(reset_req == exp_reset && resume_pulse == !exp_reset,
            exp_reset ? "R10 reset outcome (R5 R6)" : "R7 resume outcome (R4 R7)",
            {reset_req, resume_pulse}, {exp_reset, !exp_reset});
      check(core_clk_en && !halted, "R3 clock restored", {core_clk_en, halted}, 2);
      check(wdt_value == (exp_delay ? 16'hFEFF : 16'hFFFF), "R9 watchdog value",
            wdt_value, exp_delay ? 16'hFEFF : 16'hFFFF);
      @(negedge osc_clk);
      check(!resume_pulse && !reset_req, "R11 pulse one cycle", {reset_req, resume_pulse}, 0);
    end
    idle_inputs();
  endtask

  initial begin
    repeat (2) @(negedge osc_clk);
    por_n = 1'b1;
    @(negedge osc_clk);
    por_n = 1'b0;
    #1;
    check(core_clk_en && !halted && !resume_pulse && !reset_req && wdt_value == 0,
          "R1 reset state", {core_clk_en, halted, resume_pulse, reset_req}, 8);
    do_por();
    // R2: write without halt bit
    write_port(8'h7F);
    repeat (3) @(negedge osc_clk);
    check(!halted && core_clk_en, "R2 bit 7 clear ignored", {halted, core_clk_en}, 1);
    // R4: edge raised while running must not wake a later halt
    clk_opt = 2'd1;
    restart_pin = 1'b1;
    repeat (5) @(negedge osc_clk);
    check(core_clk_en && !halted, "R4 edge while running ignored", core_clk_en, 1);
    write_port(8'h80);
    repeat (20) @(negedge osc_clk);
    check(halted && !core_clk_en, "R4 stale edge no wake", halted, 1);
    restart_pin = 1'b0;
    repeat (4) @(negedge osc_clk);
    restart_pin = 1'b1;
    repeat (LAT) @(negedge osc_clk);
    check(resume_pulse && core_clk_en, "R4 fresh edge wakes", resume_pulse, 1);
    // sweep
    for (int opt = 0; opt < 4; opt++)
      for (int boe = 0; boe < 2; boe++)
        for (int mask = 0; mask < 16; mask++)
          run_case(opt, boe, mask);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge osc_clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule